// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the programming state of an I/O interrupt controller. Software sees only three bus offsets. An index register picks an internal register. A data window reads or writes the register that the index names. A separate end-of-interrupt port accepts EOI writes. Behind the window sit an identifier register, a read-only version register, and one 64-bit routing entry per input pin. Each routing entry is reached as two 32-bit halves.

The service logic beside the block reads every entry through a flat table output. It reports per-pin status back through two inputs: a delivery-busy level and a pulse that marks a level-triggered request as in service. Software writes never disturb those two status bits. Writes to a routing entry also clear stale in-service state when the entry is left in edge mode. A qualified EOI write is broadcast as a vector strobe and releases every matching in-service entry.

The bus read path is a two-state machine. In `ACC_IDLE` no read data is pending. An accepted read moves it to `ACC_RDATA`, where `bus_rvalid` is high for exactly one cycle. A further read taken in `ACC_RDATA` keeps it there, and any other cycle returns it to `ACC_IDLE`.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset the index register and ID field are 0, and every routing entry holds only its mask bit (bit 16), so both `tbl_flat` and a window read of an entry's low half show 0x00010000 while `dlv_stat` is low.
- R2: Bus offset 0x00 is the index register (8 bits, read back in bits 7:0), offset 0x10 is the data window, and offset 0x40 is the EOI port. A read is answered in the next cycle with `bus_rvalid` high for that cycle only. Reads of offsets 0x40 or any other undecoded offset return zero.
- R3: Index 0 returns the 4-bit ID in bits 27:24. A write to index 0 keeps only bits 27:24 of the data.
- R4: Index 1 reads {8'h00, NPINS-1, 8'h00, VERSION}, so with the defaults it reads 0x00170020. Writes to it change nothing.
- R5: Index 0x10+2k selects bits 31:0 of entry k, and index 0x11+2k selects bits 63:32.
- R6: Indices 2 to 0x0F, and table indices whose entry number is NPINS or more, read as zero and ignore writes.
- R7: Bits 47:17 of an entry always read zero. Bit 12 (delivery busy) and bit 14 (remote in-service) keep their value across software writes. All other bits (vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 with 1 = level, mask 16, destination 63:48) take the written value.
- R8: After any table write that leaves bit 15 at 0 (edge), bit 14 of that entry is 0.
- R9: Bit 12 of entry k follows `dlv_stat[k]` with one cycle of delay. A pulse on `rirr_set[k]` sets bit 14 only when the entry is level-triggered.
- R10: With VERSION 0x20, a 32-bit write (`bus_full`=1) to offset 0x40 raises `eoi_valid` for the next cycle with `eoi_vector` equal to data bits 7:0. It also clears bit 14 of every entry whose vector equals that value.
- R11: An EOI write is ignored, with no strobe and no in-service change, when VERSION is 0x11 or when `bus_full` is 0.
- R12: Entry k appears on `tbl_flat[64k+63:64k]` in the cycle after the write that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = 32-bit wide access |
| bus_addr | input | 8 | Low address byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe |
| rirr_set | input | NPINS | Per-pin in-service set pulse from service logic |
| dlv_stat | input | NPINS | Per-pin delivery-busy level |
| tbl_flat | output | NPINS*64 | All routing entries, entry k at bits 64k+63:64k |
| eoi_valid | output | 1 | EOI broadcast strobe |
| eoi_vector | output | 8 | Broadcast EOI vector |

## Verification
The bench first targets the status bits. It sets both read-only bits, then rewrites the entry with zeros there. A design that masked writes wrongly would lose the in-service or busy state. It then flips the entry to edge mode, where a design without the edge fix would keep a stale bit 14 that later blocks a level interrupt. Index decoding is probed at the half boundary, the first index past the last pin, the gap between index 1 and the table, and the top index. An off-by-one there would alias into a real entry. The EOI port is exercised with a wrong vector, a 16-bit access and an older-version instance, any of which would otherwise release interrupts falsely.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam logic [7:0]  OFF_SEL   = 8'h00;
    localparam logic [7:0]  OFF_WIN   = 8'h10;
    localparam logic [7:0]  OFF_EOI   = 8'h40;
    localparam logic [7:0]  IDX_ID    = 8'h00;
    localparam logic [7:0]  IDX_VER   = 8'h01;
    localparam logic [7:0]  TBL_BASE  = 8'h10;
    localparam int          ID_LSB    = 24;
    localparam int          ID_W      = 4;
    localparam int          MAXENT_LSB = 16;
    localparam int          BIT_DLV   = 12;
    localparam int          BIT_RIRR  = 14;
    localparam int          BIT_TRIG  = 15;
    localparam int          BIT_MASK  = 16;
    localparam logic [63:0] RW_BITS   = 64'hFFFF_0000_0001_AFFF;
    localparam logic [63:0] RO_BITS   = (64'd1 << BIT_DLV) | (64'd1 << BIT_RIRR);
    localparam logic [63:0] ENT_RESET = 64'd1 << BIT_MASK;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_t;
endpackage

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        dlv_stat,
    input  logic        eoi_hit,
    input  logic [7:0]  eoi_vec,
    output logic [63:0] ent
);
    logic [63:0] ent_q;
    logic [63:0] staged;
    logic [63:0] merged;
    logic [63:0] ent_d;

    always_comb begin
        staged = ent_q;
        if (wr_lo) staged[31:0]  = wdata;
        if (wr_hi) staged[63:32] = wdata;
        merged = ent_q;
        if (wr_lo || wr_hi) begin
            merged = (staged & RW_BITS) | (ent_q & RO_BITS);
            if (!merged[BIT_TRIG]) merged[BIT_RIRR] = 1'b0;
        end
        ent_d = merged;
        ent_d[BIT_DLV] = dlv_stat;
        if (eoi_hit && (ent_q[7:0] == eoi_vec)) ent_d[BIT_RIRR] = 1'b0;
        if (rirr_set && merged[BIT_TRIG]) ent_d[BIT_RIRR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= ENT_RESET;
        else        ent_q <= ent_d;
    end

    assign ent = ent_q;
endmodule

// File: rtl/irq_route_acc.sv
module irq_route_acc
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic [31:0] rd_word,
    output logic        rvalid,
    output logic [31:0] rdata
);
    acc_state_t state_q, state_d;
    logic [31:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  state_d = rd_req ? ACC_RDATA : ACC_IDLE;
            ACC_RDATA: state_d = rd_req ? ACC_RDATA : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_word;
    end

    assign rvalid = (state_q == ACC_RDATA);
    assign rdata  = rdata_q;
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic               bus_full,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic [NPINS-1:0]   rirr_set,
    input  logic [NPINS-1:0]   dlv_stat,
    output logic [NPINS*64-1:0] tbl_flat,
    output logic               eoi_valid,
    output logic [7:0]         eoi_vector
);
    localparam logic [7:0]  LAST_ENT = 8'(NPINS - 1);
    localparam logic [31:0] VER_WORD = (32'(LAST_ENT) << MAXENT_LSB) | 32'(VERSION);
    localparam bit          HAS_EOI  = (VERSION == 8'h20);

    logic [7:0]      sel_q;
    logic [ID_W-1:0] id_q;
    logic            eoi_valid_q;
    logic [7:0]      eoi_vec_q;
    logic [63:0]     ent_w [NPINS];

    logic       wr, rd, win_wr, eoi_ok;
    logic       is_tbl, ent_ok, half_hi;
    logic [7:0] ent_idx;
    logic [31:0] rd_word;
    logic [63:0] ent_pick;

    assign wr      = bus_valid && bus_write;
    assign rd      = bus_valid && !bus_write;
    assign win_wr  = wr && (bus_addr == OFF_WIN);
    assign eoi_ok  = HAS_EOI && wr && bus_full && (bus_addr == OFF_EOI);
    assign is_tbl  = (sel_q >= TBL_BASE);
    assign ent_idx = 8'(sel_q - TBL_BASE) >> 1;
    assign ent_ok  = is_tbl && (ent_idx <= LAST_ENT);
    assign half_hi = sel_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (wr && (bus_addr == OFF_SEL)) sel_q <= bus_wdata[7:0];
            if (win_wr && (sel_q == IDX_ID)) id_q <= bus_wdata[ID_LSB +: ID_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_valid_q <= 1'b0;
            eoi_vec_q   <= '0;
        end else begin
            eoi_valid_q <= eoi_ok;
            if (eoi_ok) eoi_vec_q <= bus_wdata[7:0];
        end
    end

    for (genvar k = 0; k < NPINS; k++) begin : g_ent
        logic hit;
        assign hit = win_wr && ent_ok && (ent_idx == 8'(k));
        irq_route_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && !half_hi),
            .wr_hi    (hit && half_hi),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set[k]),
            .dlv_stat (dlv_stat[k]),
            .eoi_hit  (eoi_ok),
            .eoi_vec  (bus_wdata[7:0]),
            .ent      (ent_w[k])
        );
        assign tbl_flat[64*k +: 64] = ent_w[k];
    end

    always_comb begin
        ent_pick = '0;
        for (int k = 0; k < NPINS; k++) begin
            if (ent_idx == 8'(k)) ent_pick = ent_w[k];
        end
    end

    always_comb begin
        rd_word = '0;
        if (bus_addr == OFF_SEL) begin
            rd_word = {24'd0, sel_q};
        end else if (bus_addr == OFF_WIN) begin
            if (sel_q == IDX_ID)       rd_word = 32'(id_q) << ID_LSB;
            else if (sel_q == IDX_VER) rd_word = VER_WORD;
            else if (ent_ok)           rd_word = half_hi ? ent_pick[63:32] : ent_pick[31:0];
        end
    end

    irq_route_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd),
        .rd_word (rd_word),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );

    assign eoi_valid  = eoi_valid_q;
    assign eoi_vector = eoi_vec_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic                bus_full,
    input logic [7:0]          bus_addr,
    input logic                bus_rvalid,
    input logic                eoi_valid,
    input logic [NPINS*64-1:0] tbl_flat
);
    a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    a_r10_eoi_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_valid && bus_write && bus_full && bus_addr == 8'h40));

    a_r11_eoi_version_gate: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (VERSION == 8'h20));

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        a_r8_edge_no_rirr: assert property (@(posedge clk) disable iff (!rst_n)
            !tbl_flat[64*k + 15] |-> !tbl_flat[64*k + 14]);

        a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_flat[64*k + 17 +: 31] == '0);

        a_r9_rirr_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tbl_flat[64*k + 14]) |-> tbl_flat[64*k + 15]);
    end
endmodule

bind irq_route_regfile irq_route_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_full   (bus_full),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .eoi_valid  (eoi_valid),
    .tbl_flat   (tbl_flat)
);

// File: tb/sim_irq_route_regfile.sv
`timescale 1ns/1ps
module sim_irq_route_regfile;
    localparam int NP = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0, bus_full = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [NP-1:0] rirr_set = '0, dlv_stat = '0;
    logic [31:0] rdata0, rdata1;
    logic rvalid0, rvalid1, eoi0, eoi1;
    logic [7:0] eoiv0, eoiv1;
    logic [NP*64-1:0] tbl0, tbl1;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_route_regfile #(.NPINS(NP), .VERSION(8'h20)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .bus_rvalid(rvalid0), .rirr_set(rirr_set),
        .dlv_stat(dlv_stat), .tbl_flat(tbl0), .eoi_valid(eoi0), .eoi_vector(eoiv0));

    irq_route_regfile #(.NPINS(NP), .VERSION(8'h11)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .bus_rvalid(rvalid1), .rirr_set(rirr_set),
        .dlv_stat(dlv_stat), .tbl_flat(tbl1), .eoi_valid(eoi1), .eoi_vector(eoiv1));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic full);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_full = full;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_full = 1'b1;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R2 rvalid", {63'd0, rvalid0}, 64'd1);
        d = rdata0;
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        bus_wr(8'h00, {24'd0, idx}, 1'b1);
        bus_rd(8'h10, d);
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] v);
        bus_wr(8'h00, {24'd0, idx}, 1'b1);
        bus_wr(8'h10, v, 1'b1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int k = 0; k < NP; k++)
            chk("R1 reset table", tbl0[64*k +: 64], 64'h0000_0000_0001_0000);
        bus_rd(8'h00, d);       chk("R1 select zero", d, 0);
        win_rd(8'h10, d);       chk("R1 entry0 low", d, 32'h0001_0000);
        win_rd(8'h00, d);       chk("R1 id zero", d, 0);
        @(negedge clk);
        chk("R2 rvalid single", {63'd0, rvalid0}, 0);
    endtask

    task automatic t_id_ver;
        logic [31:0] d;
        win_wr(8'h00, 32'hFFFF_FFFF);
        win_rd(8'h00, d);  chk("R3 id masked", d, 32'h0F00_0000);
        win_wr(8'h01, 32'h1234_5678);
        win_rd(8'h01, d);  chk("R4 version new", d, 32'h0017_0020);
        chk("R4 version old", rdata1, 32'h0017_0011);
        bus_wr(8'h00, 32'h0000_00A5, 1'b1);
        bus_rd(8'h00, d);  chk("R2 select readback", d, 32'h0000_00A5);
        bus_rd(8'h20, d);  chk("R2 undecoded offset", d, 0);
        bus_rd(8'h40, d);  chk("R2 eoi offset reads zero", d, 0);
    endtask

    task automatic t_halves;
        logic [31:0] d;
        win_wr(8'h1A, 32'h0000_2931);
        chk("R12 table after write", tbl0[64*5 +: 64], 64'h0000_0000_0000_2931);
        win_wr(8'h1B, 32'hAB00_0000);
        win_rd(8'h1A, d);  chk("R5 even half", d, 32'h0000_2931);
        win_rd(8'h1B, d);  chk("R5 odd half", d, 32'hAB00_0000);
        chk("R12 entry5 full", tbl0[64*5 +: 64], 64'hAB00_0000_0000_2931);
        chk("R12 entry4 untouched", tbl0[64*4 +: 64], 64'h0000_0000_0001_0000);
        win_wr(8'h2F, 32'hFFFF_FFFF);
        win_rd(8'h2F, d);  chk("R7 high mask", d, 32'hFFFF_0000);
        win_wr(8'h2E, 32'hFFFF_FFFF);
        win_rd(8'h2E, d);  chk("R7 low mask", d, 32'h0001_AFFF);
    endtask

    task automatic t_range;
        logic [31:0] d;
        win_wr(8'h40, 32'hFFFF_FFFF);
        win_rd(8'h40, d);  chk("R6 past last pin", d, 0);
        win_rd(8'h3F, d);  chk("R6 last pin high", d, 0);
        win_wr(8'h05, 32'hFFFF_FFFF);
        win_rd(8'h05, d);  chk("R6 gap index", d, 0);
        win_rd(8'hFF, d);  chk("R6 top index", d, 0);
        for (int k = 0; k < NP; k++)
            if (k != 5 && k != 15)
                chk("R6 no alias write", tbl0[64*k +: 64], 64'h0000_0000_0001_0000);
    endtask

    task automatic t_status;
        logic [31:0] d;
        dlv_stat[3] = 1'b1;
        win_wr(8'h16, 32'h0000_8031);
        @(negedge clk); rirr_set[3] = 1'b1;
        @(negedge clk); rirr_set[3] = 1'b0;
        chk("R9 rirr set level", {63'd0, tbl0[64*3 + 14]}, 1);
        chk("R9 dlv follows", {63'd0, tbl0[64*3 + 12]}, 1);
        win_wr(8'h16, 32'h0000_8032);
        win_rd(8'h16, d);  chk("R7 ro kept", d, 32'h0000_D032);
        win_wr(8'h16, 32'h0000_0032);
        win_rd(8'h16, d);  chk("R8 edge clears rirr", d, 32'h0000_1032);
        @(negedge clk); rirr_set[3] = 1'b1;
        @(negedge clk); rirr_set[3] = 1'b0;
        chk("R9 no set on edge", {63'd0, tbl0[64*3 + 14]}, 0);
        dlv_stat[3] = 1'b0;
        @(negedge clk);
        chk("R9 dlv drops", {63'd0, tbl0[64*3 + 12]}, 0);
    endtask

    task automatic t_eoi;
        win_wr(8'h18, 32'h0000_8044);
        @(negedge clk); rirr_set[4] = 1'b1;
        @(negedge clk); rirr_set[4] = 1'b0;
        chk("R9 rirr set new", {63'd0, tbl0[64*4 + 14]}, 1);
        chk("R9 rirr set old", {63'd0, tbl1[64*4 + 14]}, 1);
        bus_wr(8'h40, 32'h0000_0045, 1'b1);
        chk("R10 strobe", {63'd0, eoi0}, 1);
        chk("R10 vector", {56'd0, eoiv0}, 64'h45);
        chk("R10 wrong vector keeps", {63'd0, tbl0[64*4 + 14]}, 1);
        bus_wr(8'h40, 32'h0000_0044, 1'b0);
        chk("R11 narrow no strobe", {63'd0, eoi0}, 0);
        chk("R11 narrow keeps rirr", {63'd0, tbl0[64*4 + 14]}, 1);
        bus_wr(8'h40, 32'h0000_0044, 1'b1);
        chk("R10 strobe match", {63'd0, eoi0}, 1);
        chk("R10 rirr cleared", {63'd0, tbl0[64*4 + 14]}, 0);
        chk("R11 old version no strobe", {63'd0, eoi1}, 0);
        chk("R11 old version keeps rirr", {63'd0, tbl1[64*4 + 14]}, 1);
        @(negedge clk);
        chk("R10 strobe single", {63'd0, eoi0}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_ver();
        t_halves();
        t_range();
        t_status();
        t_eoi();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule